// File: doc/BRIEF.md
# Virtual Address Region Classifier

This block looks at a 64-bit virtual address before a page-table walk begins and decides which half of the address space it belongs to. The address space is split into a low half, whose addresses have all upper bits clear, and a high half, whose addresses have all upper bits set. Each half has its own programmable size field, and the field holds 64 minus the width of that half in bits. An address that belongs to neither half lies in the unmapped gap and raises a translation fault. Only a 4 KB granule is supported, so each table level resolves 9 address bits above a 12-bit page offset.

For a legal address the block selects the matching base register: base register 0 for the low half and base register 1 for the high half. It also reports the table level at which the walk starts and the most and least significant VA bits that index that first level. A narrower half skips upper levels. A full 48-bit half starts at level 0, and a 39-bit half starts at level 1. Results are registered and appear one cycle after an input strobe.

The result is held in a four-state machine. **ST_IDLE** is the state after reset, before any result exists. **ST_LOW** holds a low-half result, **ST_HIGH** holds a high-half result and **ST_FAULT** holds a gap result. From every state, a strobe moves the machine to the state that matches the new address: the *to-low*, *to-high* and *to-fault* transitions. Without a strobe the machine stays where it is (the *hold* transition).

Top module: `va_region_classifier`

## Requirements
- R1: While reset is held and after its release, before any strobe, out_valid, out_fault, out_sel, out_level, out_idx_msb and out_idx_lsb are all zero.
- R2: out_valid is high in exactly the cycle that follows a cycle with in_valid high. All other outputs change only in that cycle and otherwise hold their last value.
- R3: An address with bit 63 clear whose bits from the low width up to bit 63 are all zero is in the low half. It gives out_sel = 2'b01 (bit 0 selects base register 0) and out_fault = 0.
- R4: An address with bit 63 set whose bits from the high width up to bit 63 are all one is in the high half. It gives out_sel = 2'b10 (bit 1 selects base register 1) and out_fault = 0.
- R5: Any other address gives out_fault = 1, out_sel = 2'b00 and zero on out_level, out_idx_msb and out_idx_lsb. With full 48-bit halves, 0x0001_0000_0000_0000 and 0xFFFE_FFFF_FFFF_FFFF both fault.
- R6: The width of a half is 64 minus its own size field. The low half uses only lo_size and the high half uses only hi_size.
- R7: The starting level on out_level is 0 for widths 40 to 48, 1 for widths 31 to 39, 2 for widths 22 to 30 and 3 for widths 13 to 21.
- R8: For a legal address, out_idx_msb equals the width minus 1 and out_idx_lsb equals 12 + 9*(3 - level). The lsb is therefore 39, 30, 21 or 12.
- R9: A size field below 16 acts as 16 (width 48), and a size field above 51 acts as 51 (width 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: classify in_va this cycle |
| in_va | input | 64 | Virtual address |
| lo_size | input | 6 | Low-half size field (64 minus width) |
| hi_size | input | 6 | High-half size field (64 minus width) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_fault | output | 1 | Address lies in the unmapped gap |
| out_sel | output | 2 | One-hot base register select; bit 0 is base 0, bit 1 is base 1 |
| out_level | output | 2 | Starting table level |
| out_idx_msb | output | 6 | Highest VA bit indexing the starting level |
| out_idx_lsb | output | 6 | Lowest VA bit indexing the starting level |

## Verification
The assertions assume that in_va, lo_size and hi_size are stable and known at every edge where in_valid is high. They also assume that the fixed checks on the top 16 address bits are meaningful only because every legal width is at most 48. The bench drives all inputs at the falling edge, so every value is settled before the edge that samples it. It sweeps the exact boundary addresses of each half at widths 48, 39, 30, 21 and 13, covers out-of-range size fields, and adds pseudo-random addresses that are shaped toward each half, idle gaps and back-to-back strobes.

// File: rtl/va_cls_pkg.sv
package va_cls_pkg;

    // Classification result held by the controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_FAULT = 2'd3
    } cls_state_e;

    // Index of the two halves.
    localparam int HALF_LO = 0;
    localparam int HALF_HI = 1;
    localparam int HALVES  = 2;

endpackage

// File: rtl/va_width_decode.sv
// Turns a size field (VA_W minus width) into a clamped region width.
module va_width_decode #(
    parameter int VA_W  = 64,
    parameter int MAX_W = 48,
    parameter int MIN_W = 13,
    localparam int IDX_W = $clog2(VA_W),
    localparam int WID_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] size_field,
    output logic [WID_W-1:0] width
);
    localparam int SIZE_LO = VA_W - MAX_W;
    localparam int SIZE_HI = VA_W - MIN_W;

    always_comb begin
        int s;
        s = int'(size_field);
        if (s < SIZE_LO) begin
            s = SIZE_LO;
        end else if (s > SIZE_HI) begin
            s = SIZE_HI;
        end
        width = WID_W'(VA_W - s);
    end
endmodule

// File: rtl/va_span_check.sv
// Reports whether every address bit at or above 'width' is zero, or is one.
module va_span_check #(
    parameter int VA_W = 64,
    localparam int WID_W = $clog2(VA_W) + 1
) (
    input  logic [VA_W-1:0]  va,
    input  logic [WID_W-1:0] width,
    output logic             upper_zero,
    output logic             upper_ones
);
    logic [VA_W-1:0] above;

    for (genvar b = 0; b < VA_W; b++) begin : g_mask
        assign above[b] = (b >= int'(width));
    end

    assign upper_zero = ~|(va & above);
    assign upper_ones = &(va | ~above);
endmodule

// File: rtl/va_level_calc.sv
// Maps a region width to the first walk level and its index bit range.
module va_level_calc #(
    parameter int VA_W       = 64,
    parameter int MAX_W      = 48,
    parameter int GRAN_SHIFT = 12,
    parameter int LVL_BITS   = 9,
    parameter int LEVELS     = 4,
    localparam int IDX_W = $clog2(VA_W),
    localparam int WID_W = IDX_W + 1,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [WID_W-1:0] width,
    output logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx_msb,
    output logic [IDX_W-1:0] idx_lsb
);
    // Top width each level can resolve on its own.
    logic [LEVELS-1:0] fits;

    for (genvar l = 0; l < LEVELS; l++) begin : g_fit
        localparam int CEIL = MAX_W - LVL_BITS * l;
        assign fits[l] = (int'(width) <= CEIL);
    end

    always_comb begin
        level   = '0;
        idx_lsb = IDX_W'(GRAN_SHIFT + LVL_BITS * (LEVELS - 1));
        for (int l = 0; l < LEVELS; l++) begin
            if (fits[l]) begin
                level   = LVL_W'(l);
                idx_lsb = IDX_W'(GRAN_SHIFT + LVL_BITS * (LEVELS - 1 - l));
            end
        end
        idx_msb = IDX_W'(int'(width) - 1);
    end
endmodule

// File: rtl/va_region_classifier.sv
module va_region_classifier
    import va_cls_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int MAX_W      = 48,
    parameter int MIN_W      = 13,
    parameter int GRAN_SHIFT = 12,
    parameter int LVL_BITS   = 9,
    parameter int LEVELS     = 4,
    localparam int IDX_W = $clog2(VA_W),
    localparam int WID_W = IDX_W + 1,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VA_W-1:0]  in_va,
    input  logic [IDX_W-1:0] lo_size,
    input  logic [IDX_W-1:0] hi_size,
    output logic             out_valid,
    output logic             out_fault,
    output logic [1:0]       out_sel,
    output logic [LVL_W-1:0] out_level,
    output logic [IDX_W-1:0] out_idx_msb,
    output logic [IDX_W-1:0] out_idx_lsb
);
    logic [IDX_W-1:0] size_f  [HALVES];
    logic [WID_W-1:0] width_h [HALVES];
    logic             zero_h  [HALVES];
    logic             ones_h  [HALVES];
    logic [LVL_W-1:0] lvl_h   [HALVES];
    logic [IDX_W-1:0] msb_h   [HALVES];
    logic [IDX_W-1:0] lsb_h   [HALVES];

    assign size_f[HALF_LO] = lo_size;
    assign size_f[HALF_HI] = hi_size;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        va_width_decode #(
            .VA_W (VA_W),
            .MAX_W(MAX_W),
            .MIN_W(MIN_W)
        ) u_width (
            .size_field(size_f[h]),
            .width     (width_h[h])
        );

        va_span_check #(
            .VA_W(VA_W)
        ) u_span (
            .va        (in_va),
            .width     (width_h[h]),
            .upper_zero(zero_h[h]),
            .upper_ones(ones_h[h])
        );

        va_level_calc #(
            .VA_W      (VA_W),
            .MAX_W     (MAX_W),
            .GRAN_SHIFT(GRAN_SHIFT),
            .LVL_BITS  (LVL_BITS),
            .LEVELS    (LEVELS)
        ) u_level (
            .width  (width_h[h]),
            .level  (lvl_h[h]),
            .idx_msb(msb_h[h]),
            .idx_lsb(lsb_h[h])
        );
    end

    // Classification of the address presented this cycle.
    logic       va_top;
    logic       lo_hit;
    logic       hi_hit;
    cls_state_e decided;

    assign va_top = in_va[VA_W-1];
    assign lo_hit = !va_top && zero_h[HALF_LO];
    assign hi_hit =  va_top && ones_h[HALF_HI];

    always_comb begin
        if (lo_hit) begin
            decided = ST_LOW;
        end else if (hi_hit) begin
            decided = ST_HIGH;
        end else begin
            decided = ST_FAULT;
        end
    end

    // Next-state logic.
    cls_state_e state;
    cls_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nxt = decided;
            ST_LOW:   if (in_valid) state_nxt = decided;
            ST_HIGH:  if (in_valid) state_nxt = decided;
            ST_FAULT: if (in_valid) state_nxt = decided;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Registered walk-start fields, loaded with each strobe.
    logic             valid_q;
    logic [LVL_W-1:0] level_q;
    logic [IDX_W-1:0] msb_q;
    logic [IDX_W-1:0] lsb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            level_q <= '0;
            msb_q   <= '0;
            lsb_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                unique case (decided)
                    ST_LOW: begin
                        level_q <= lvl_h[HALF_LO];
                        msb_q   <= msb_h[HALF_LO];
                        lsb_q   <= lsb_h[HALF_LO];
                    end
                    ST_HIGH: begin
                        level_q <= lvl_h[HALF_HI];
                        msb_q   <= msb_h[HALF_HI];
                        lsb_q   <= lsb_h[HALF_HI];
                    end
                    default: begin
                        level_q <= '0;
                        msb_q   <= '0;
                        lsb_q   <= '0;
                    end
                endcase
            end
        end
    end

    // Output decode from the held state.
    always_comb begin
        out_valid   = valid_q;
        out_level   = level_q;
        out_idx_msb = msb_q;
        out_idx_lsb = lsb_q;
        out_fault   = 1'b0;
        out_sel     = 2'b00;
        unique case (state)
            ST_IDLE:  out_sel = 2'b00;
            ST_LOW:   out_sel = 2'b01;
            ST_HIGH:  out_sel = 2'b10;
            ST_FAULT: out_fault = 1'b1;
            default:  out_sel = 2'b00;
        endcase
    end
endmodule

// File: rtl/va_region_classifier_chk.sv
module va_region_classifier_chk #(
    parameter int VA_W     = 64,
    parameter int MAX_W    = 48,
    parameter int SIZE_LO  = 16,
    parameter int LVL_W    = 2,
    localparam int IDX_W = $clog2(VA_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VA_W-1:0]  in_va,
    input logic [IDX_W-1:0] lo_size,
    input logic [IDX_W-1:0] hi_size,
    input logic             out_valid,
    input logic             out_fault,
    input logic [1:0]       out_sel,
    input logic [LVL_W-1:0] out_level,
    input logic [IDX_W-1:0] out_idx_msb,
    input logic [IDX_W-1:0] out_idx_lsb
);
    logic [VA_W-MAX_W-1:0] top_bits;
    assign top_bits = in_va[VA_W-1:MAX_W];

    // R2: result strobe follows every input strobe
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no result strobe without an input strobe
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: results hold between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sel) && $stable(out_fault)
                       && $stable(out_level) && $stable(out_idx_msb)
                       && $stable(out_idx_lsb)));

    // R3 R4: at most one base register selected
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_sel));

    // R5: a fault selects no base register and clears the walk fields
    p_fault_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_sel == 2'b00 && out_level == '0
                       && out_idx_msb == '0 && out_idx_lsb == '0));

    // R5: mixed bits above the widest half always fault
    p_mixed_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|top_bits) && !(&top_bits)) |=> out_fault);

    // R8: the index field of a legal result spans at most one level
    p_idx_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |->
            (out_idx_msb >= out_idx_lsb && (out_idx_msb - out_idx_lsb) < 6'd9));

    // R9: an undersized low field still treats a short address as low
    p_clamp_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(lo_size) < SIZE_LO && top_bits == '0) |=> out_sel == 2'b01);
endmodule

bind va_region_classifier va_region_classifier_chk #(
    .VA_W (VA_W),
    .MAX_W(MAX_W),
    .SIZE_LO(VA_W - MAX_W),
    .LVL_W(LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_va      (in_va),
    .lo_size    (lo_size),
    .hi_size    (hi_size),
    .out_valid  (out_valid),
    .out_fault  (out_fault),
    .out_sel    (out_sel),
    .out_level  (out_level),
    .out_idx_msb(out_idx_msb),
    .out_idx_lsb(out_idx_lsb)
);

// File: tb/tb_va_region_classifier.sv
`timescale 1ns/1ps
module tb_va_region_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_va = '0;
    logic [5:0]  lo_size = 6'd16;
    logic [5:0]  hi_size = 6'd16;
    logic        out_valid;
    logic        out_fault;
    logic [1:0]  out_sel;
    logic [1:0]  out_level;
    logic [5:0]  out_idx_msb;
    logic [5:0]  out_idx_lsb;

    always #5 clk = ~clk;

    va_region_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(in_va),
        .lo_size(lo_size), .hi_size(hi_size), .out_valid(out_valid),
        .out_fault(out_fault), .out_sel(out_sel), .out_level(out_level),
        .out_idx_msb(out_idx_msb), .out_idx_lsb(out_idx_lsb)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    // Behavioural reference from the requirements.
    function automatic void ref_eval(input logic [63:0] va, input int lo_s, input int hi_s,
                                     output int sel, output int fault, output int lvl,
                                     output int msb, output int lsb);
        int  s;
        int  w;
        bit  hi;
        bit  ok;
        hi = va[63];
        s  = hi ? hi_s : lo_s;
        if (s < 16) s = 16;   // R9
        if (s > 51) s = 51;
        w  = 64 - s;          // R6
        ok = 1;
        for (int b = w; b < 64; b++) if (va[b] != hi) ok = 0;
        if (!ok) begin
            sel = 0; fault = 1; lvl = 0; msb = 0; lsb = 0;
        end else begin
            sel   = hi ? 2 : 1;
            fault = 0;
            if (w >= 40)      lvl = 0;
            else if (w >= 31) lvl = 1;
            else if (w >= 22) lvl = 2;
            else              lvl = 3;
            msb = w - 1;
            lsb = 39 - 9 * lvl;
        end
    endfunction

    int exp_valid = 0, exp_sel = 0, exp_fault = 0, exp_lvl = 0, exp_msb = 0, exp_lsb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid = 0; exp_sel = 0; exp_fault = 0; exp_lvl = 0; exp_msb = 0; exp_lsb = 0;
        end else begin
            exp_valid = int'(in_valid);
            if (in_valid)
                ref_eval(in_va, int'(lo_size), int'(hi_size),
                         exp_sel, exp_fault, exp_lvl, exp_msb, exp_lsb);
        end
    end

    task automatic chk(input string field, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (va=%h lo=%0d hi=%0d)",
                     phase, field, act, exp, in_va, lo_size, hi_size);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("valid R2", int'(out_valid), exp_valid);
            chk("sel R3 R4 R5", int'(out_sel), exp_sel);
            chk("fault R5", int'(out_fault), exp_fault);
            chk("level R7", int'(out_level), exp_lvl);
            chk("msb R8", int'(out_idx_msb), exp_msb);
            chk("lsb R8", int'(out_idx_lsb), exp_lsb);
        end
    end

    task automatic drive(input logic [63:0] va, input int lo, input int hi);
        @(negedge clk);
        in_valid = 1'b1;
        in_va    = va;
        lo_size  = 6'(lo);
        hi_size  = 6'(hi);
    endtask

    task automatic idle(input logic [63:0] junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_va    = junk;
    endtask

    task automatic sweep(input int s);
        logic [63:0] lim;
        int w;
        w   = 64 - s;
        lim = (64'd1 << w) - 64'd1;
        drive(64'd0, s, s);
        drive(lim, s, s);
        drive(lim + 64'd1, s, s);
        drive(~lim, s, s);
        drive(~lim - 64'd1, s, s);
        drive(~64'd0, s, s);
        drive(64'h8000_0000_0000_0000, s, s);
        idle(64'h1234_5678_9ABC_DEF0);
    endtask

    logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        phase = "R3 R4 R5 R7 R8 sweep";
        sweep(16); sweep(25); sweep(34); sweep(43); sweep(51);
        sweep(20); sweep(33);

        phase = "R5";
        drive(64'h0001_0000_0000_0000, 16, 16);
        drive(64'hFFFE_FFFF_FFFF_FFFF, 16, 16);
        drive(64'h0000_0080_0000_0000, 25, 25);
        drive(64'hFFFF_FF7F_FFFF_FFFF, 25, 25);

        phase = "R6";
        drive(64'h0000_FFFF_FFFF_FFFF, 16, 51);
        drive(64'hFFFF_FFFF_FFFF_F000, 16, 51);
        drive(64'hFFFF_FFFF_FFFF_EFFF, 16, 51);
        drive(64'h0000_0000_0000_1FFF, 51, 16);
        drive(64'h0000_0000_0000_2000, 51, 16);
        drive(64'hFFFF_0000_0000_0000, 51, 16);

        phase = "R2";
        idle(64'h0001_0000_0000_0000);
        idle(64'hFFFF_0000_0000_0000);
        drive(64'h0000_0000_0000_0001, 16, 16);
        idle(64'hDEAD_0000_0000_0000);
        idle(64'h0);

        phase = "R9";
        drive(64'h0000_FFFF_FFFF_FFFF, 0, 0);
        drive(64'hFFFF_0000_0000_0000, 3, 3);
        drive(64'h0001_0000_0000_0000, 0, 0);
        drive(64'h0000_0000_0000_1FFF, 63, 63);
        drive(64'h0000_0000_0000_2000, 63, 63);
        drive(64'hFFFF_FFFF_FFFF_E000, 60, 60);

        phase = "R3 R4 R5 R6 R9 mixed";
        for (int i = 0; i < 300; i++) begin
            logic [63:0] va;
            int lo;
            int hi;
            x ^= x << 13; x ^= x >> 7; x ^= x << 17;
            va = x;
            lo = int'(x[13:8]);
            hi = int'(x[19:14]);
            case (x[22:21])
                2'd1: va = va & ((64'd1 << (64 - (lo < 16 ? 16 : lo > 51 ? 51 : lo))) - 64'd1);
                2'd2: va = va | ~((64'd1 << (64 - (hi < 16 ? 16 : hi > 51 ? 51 : hi))) - 64'd1);
                default: ;
            endcase
            if (x[30]) idle(x);
            drive(va, lo, hi);
        end
        idle(64'h0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule